// File: doc/BRIEF.md
# Multi-Mode Pulse Counter with Capture and Compare

This block counts pulses from an encoder or a sensor with no help from a host. A 32-bit count register follows the inputs on its own. It can count up on rising edges of a single pulse line, count down on those edges, or decode an A/B quadrature pair at four counts per cycle. The pair's phase order sets the direction. All inputs are assumed to be synchronised into the clock domain already.

Around the count sit four helpers:

- A capture register takes the count when an external trigger rises.
- An equality comparator gives a one-cycle output pulse and a sticky interrupt flag when the count reaches a preset.
- A snapshot request copies the count and its rollover extension into shadow registers in one cycle, so the host reads a coherent pair.
- An extension counter tracks wraps past the top and bottom of the 32-bit range.

A host reaches the registers through a plain write strobe, a 3-bit address and a combinational read port. A load strobe presets the count.

Top module: `pulse_counter_top`

## Requirements
- R1: After reset, every readable register and the extension counter read zero, `irq_o` is low, and `cmp_pulse_o` is low.
- R2: With `mode_i` = 0 (up), each rising edge of `pulse_i` adds one to the count, and the new value shows at address 0 in the cycle after the edge is sampled. With no step and no load, the count holds.
- R3: With `mode_i` = 1 (down), each rising edge of `pulse_i` subtracts one from the count. With `mode_i` = 3, the count does not move.
- R4: With `mode_i` = 2 (quadrature), the phase pair {A,B} stepping through 00, 01, 11, 10 and back to 00 adds one per change. Stepping through the same states in reverse subtracts one per change.
- R5: In quadrature mode, a sample where A and B both change leaves the count unchanged and sets bit 1 of the status register (address 6). That bit stays set until the host writes 1 to it.
- R6: A rising edge on `capture_i` loads the capture register (address 1) with the count held during that cycle, before any step taken in the same cycle.
- R7: When the count becomes equal to the preset (address 4), `cmp_pulse_o` is high for exactly one cycle. It does not fire again while the count stays equal, and it does not fire just after reset. In the next cycle `irq_o` and status bit 0 set. They stay set until the host writes 1 to status bit 0. A set in the same cycle wins over the clear.
- R8: While `snap_i` is high, the shadow count (address 2) and shadow extension (address 3) take the present count and extension together. The count keeps stepping in that same cycle.
- R9: A step up from 0xFFFFFFFF to 0 adds one to the 16-bit extension counter (address 7). A step down from 0 to 0xFFFFFFFF subtracts one from it. A load leaves the extension counter unchanged.
- R10: When `load_i` is high, the count takes the load value register (address 5), even if a count step arrives in the same cycle.
- R11: Register map: 0 count, 1 capture, 2 shadow count, 3 shadow extension, 4 preset (read/write), 5 load value (read/write), 6 status {bit1 quadrature error, bit0 interrupt} (write 1 to clear), 7 live extension. Writes to addresses 0 to 3 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | 0 up, 1 down, 2 quadrature, 3 hold |
| pulse_i | input | 1 | Count pulse for the up and down modes |
| phase_a_i | input | 1 | Quadrature phase A |
| phase_b_i | input | 1 | Quadrature phase B |
| capture_i | input | 1 | Capture trigger, acts on its rising edge |
| snap_i | input | 1 | Snapshot request, level sampled each cycle |
| load_i | input | 1 | Preset the count from the load value register |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| cmp_pulse_o | output | 1 | One-cycle compare match pulse |
| irq_o | output | 1 | Sticky compare interrupt flag |

## Verification
The hardest states to reach are the two ends of the 32-bit range, where the extension counter must move. Stepping there from reset would take billions of pulses, so the stimulus loads 0xFFFFFFFE through the load value register and then steps up across the top and back down across zero. Other corners need two events in the same cycle: a load together with a pulse edge, a capture trigger together with a step, and a snapshot together with a step. Each of these is driven in a single cycle. A behavioural reference model compares every readable register and both outputs on every clock.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_QUAD = 2'd2,
    MODE_HOLD = 2'd3
  } cnt_mode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAPT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_SHCNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SHEXT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRESET = 3'd4;
  localparam logic [ADDR_W-1:0] A_LDVAL  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd6;
  localparam logic [ADDR_W-1:0] A_EXT    = 3'd7;

endpackage

// File: rtl/pcnt_step_gen.sv
module pcnt_step_gen
  import pcnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cnt_mode_e mode,
  input  logic      pulse_i,
  input  logic      phase_a_i,
  input  logic      phase_b_i,
  output logic      step_up_o,
  output logic      step_dn_o,
  output logic      bad_o
);

  logic pulse_q, a_q, b_q;
  logic pulse_edge, ch_a, ch_b;

  // previous samples of the count inputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      a_q     <= 1'b0;
      b_q     <= 1'b0;
    end else begin
      pulse_q <= pulse_i;
      a_q     <= phase_a_i;
      b_q     <= phase_b_i;
    end
  end

  always_comb begin
    pulse_edge = pulse_i & ~pulse_q;
    ch_a       = phase_a_i ^ a_q;
    ch_b       = phase_b_i ^ b_q;
    step_up_o  = 1'b0;
    step_dn_o  = 1'b0;
    bad_o      = 1'b0;
    case (mode)
      MODE_UP:   step_up_o = pulse_edge;
      MODE_DOWN: step_dn_o = pulse_edge;
      MODE_QUAD: begin
        if (ch_a && ch_b) begin
          bad_o = 1'b1;
        end else if (ch_a || ch_b) begin
          // forward order 00,01,11,10: old A differs from new B
          if (a_q ^ phase_b_i) step_up_o = 1'b1;
          else                 step_dn_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pcnt_accum.sv
module pcnt_accum #(
  parameter int CNT_W = 32,
  parameter int EXT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [EXT_W-1:0] ext_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [EXT_W-1:0] EXT_ONE = {{(EXT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] ext_q, ext_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    ext_d  = ext_q;
    cnt_en = load_i | step_up_i | step_dn_i;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (step_up_i) begin
      cnt_d = cnt_q + CNT_ONE;
      if (cnt_q == CNT_MAX) ext_d = ext_q + EXT_ONE;
    end else if (step_dn_i) begin
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == '0) ext_d = ext_q - EXT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ext_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ext_q <= ext_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ext_o = ext_q;

endmodule

// File: rtl/pcnt_regfile.sv
module pcnt_regfile
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int EXT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic              capture_i,
  input  logic              snap_i,
  input  logic              bad_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              cmp_pulse_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  reg_rdata_o
);

  logic [CNT_W-1:0] capt_q, capt_d, shc_q, shc_d, pre_q, pre_d, ldv_q, ldv_d;
  logic [EXT_W-1:0] she_q, she_d;
  logic             cap_q, eq_q, eq, irq_q, irq_d, qerr_q, qerr_d;
  logic             cap_edge, w_stat;
  logic [CNT_W-1:0] ext_rd, she_rd;

  generate
    if (EXT_W < CNT_W) begin : g_ext_pad
      assign ext_rd = {{(CNT_W-EXT_W){1'b0}}, ext_i};
      assign she_rd = {{(CNT_W-EXT_W){1'b0}}, she_q};
    end else begin : g_ext_trim
      assign ext_rd = ext_i[CNT_W-1:0];
      assign she_rd = she_q[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    cap_edge    = capture_i & ~cap_q;
    eq          = (cnt_i == pre_q);
    cmp_pulse_o = eq & ~eq_q;
    w_stat      = reg_we_i && (reg_addr_i == A_STATUS);
    capt_d      = cap_edge ? cnt_i : capt_q;
    shc_d       = snap_i ? cnt_i : shc_q;
    she_d       = snap_i ? ext_i : she_q;
    pre_d       = (reg_we_i && reg_addr_i == A_PRESET) ? reg_wdata_i : pre_q;
    ldv_d       = (reg_we_i && reg_addr_i == A_LDVAL)  ? reg_wdata_i : ldv_q;
    irq_d       = cmp_pulse_o | (irq_q & ~(w_stat & reg_wdata_i[0]));
    qerr_d      = bad_i | (qerr_q & ~(w_stat & reg_wdata_i[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_q <= '0;
      shc_q  <= '0;
      she_q  <= '0;
      pre_q  <= '0;
      ldv_q  <= '0;
      cap_q  <= 1'b0;
      eq_q   <= 1'b1;
      irq_q  <= 1'b0;
      qerr_q <= 1'b0;
    end else begin
      capt_q <= capt_d;
      shc_q  <= shc_d;
      she_q  <= she_d;
      pre_q  <= pre_d;
      ldv_q  <= ldv_d;
      cap_q  <= capture_i;
      eq_q   <= eq;
      irq_q  <= irq_d;
      qerr_q <= qerr_d;
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_COUNT:  reg_rdata_o = cnt_i;
      A_CAPT:   reg_rdata_o = capt_q;
      A_SHCNT:  reg_rdata_o = shc_q;
      A_SHEXT:  reg_rdata_o = she_rd;
      A_PRESET: reg_rdata_o = pre_q;
      A_LDVAL:  reg_rdata_o = ldv_q;
      A_STATUS: reg_rdata_o = {{(CNT_W-2){1'b0}}, qerr_q, irq_q};
      default:  reg_rdata_o = ext_rd;
    endcase
  end

  assign load_val_o = ldv_q;
  assign irq_o      = irq_q;

endmodule

// File: rtl/pulse_counter_top.sv
module pulse_counter_top
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int EXT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              pulse_i,
  input  logic              phase_a_i,
  input  logic              phase_b_i,
  input  logic              capture_i,
  input  logic              snap_i,
  input  logic              load_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              cmp_pulse_o,
  output logic              irq_o
);

  logic [1:0]       rst_sync;
  logic             rst_n_s;
  logic             step_up, step_dn, quad_bad;
  logic [CNT_W-1:0] cnt_w, load_val;
  logic [EXT_W-1:0] ext_w;

  // reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  pcnt_step_gen u_step (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mode      (cnt_mode_e'(mode_i)),
    .pulse_i   (pulse_i),
    .phase_a_i (phase_a_i),
    .phase_b_i (phase_b_i),
    .step_up_o (step_up),
    .step_dn_o (step_dn),
    .bad_o     (quad_bad)
  );

  pcnt_accum #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .step_up_i  (step_up),
    .step_dn_i  (step_dn),
    .load_i     (load_i),
    .load_val_i (load_val),
    .cnt_o      (cnt_w),
    .ext_o      (ext_w)
  );

  pcnt_regfile #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cnt_i       (cnt_w),
    .ext_i       (ext_w),
    .capture_i   (capture_i),
    .snap_i      (snap_i),
    .bad_i       (quad_bad),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .load_val_o  (load_val),
    .cmp_pulse_o (cmp_pulse_o),
    .irq_o       (irq_o),
    .reg_rdata_o (reg_rdata_o)
  );

endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker #(
  parameter int CNT_W = 32,
  parameter int EXT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_up,
  input logic             step_dn,
  input logic             quad_bad,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] cnt,
  input logic [EXT_W-1:0] ext,
  input logic             cmp_pulse_o,
  input logic             irq_o
);

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !load_i) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !load_i) |=> $stable(cnt));

  p_step_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !load_i) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  p_bad_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_bad && !load_i) |=> $stable(cnt));

  p_cmp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse_o |=> !cmp_pulse_o);

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse_o |=> irq_o);

  p_wrap_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !load_i && cnt == {CNT_W{1'b1}}) |=> (ext == EXT_W'($past(ext) + 1'b1)));

  p_wrap_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !load_i && cnt == '0) |=> (ext == EXT_W'($past(ext) - 1'b1)));

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt == $past(load_val)));

  p_load_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> $stable(ext));

endmodule

bind pulse_counter_top pcnt_checker #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_pcnt_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .step_up     (step_up),
  .step_dn     (step_dn),
  .quad_bad    (quad_bad),
  .load_i      (load_i),
  .load_val    (load_val),
  .cnt         (cnt_w),
  .ext         (ext_w),
  .cmp_pulse_o (cmp_pulse_o),
  .irq_o       (irq_o)
);

// File: tb/tb_pulse_counter_top.sv
`timescale 1ns/1ps
module tb_pulse_counter_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        pulse, pa, pb, cap, snap, load, we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        cmp, irq;

  int checks = 0;
  int errors = 0;
  int cmp_seen = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  pulse_counter_top dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .pulse_i(pulse),
    .phase_a_i(pa), .phase_b_i(pb), .capture_i(cap), .snap_i(snap),
    .load_i(load), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cmp_pulse_o(cmp), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  int unsigned m_cnt, m_cap, m_sc, m_pre, m_ldv;
  int          m_ext, m_se;
  bit          m_irq, m_qerr, m_eqq, m_pq, m_cq, m_pa, m_pb;

  function automatic int qpos(input bit a, input bit b);
    case ({a, b})
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit up, dn, bad, eq;
    int d;
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_sc = 0; m_pre = 0; m_ldv = 0;
      m_ext = 0; m_se = 0; m_irq = 0; m_qerr = 0; m_eqq = 1;
      m_pq = 0; m_cq = 0; m_pa = 0; m_pb = 0;
    end else begin
      up = 0; dn = 0; bad = 0;
      eq = (m_cnt == m_pre);
      if (mode == 2'd0) up = pulse && !m_pq;
      else if (mode == 2'd1) dn = pulse && !m_pq;
      else if (mode == 2'd2) begin
        d = (qpos(pa, pb) - qpos(m_pa, m_pb) + 4) % 4;
        up = (d == 1); dn = (d == 3); bad = (d == 2);
      end
      if (cap && !m_cq) m_cap = m_cnt;
      if (snap) begin m_sc = m_cnt; m_se = m_ext; end
      if (we && addr == 3'd6 && wdata[0]) m_irq = 0;
      if (we && addr == 3'd6 && wdata[1]) m_qerr = 0;
      if (eq && !m_eqq) m_irq = 1;
      if (bad) m_qerr = 1;
      if (load) m_cnt = m_ldv;
      else if (up) begin
        if (m_cnt == 32'hFFFF_FFFF) m_ext = m_ext + 1;
        m_cnt = m_cnt + 1;
      end else if (dn) begin
        if (m_cnt == 0) m_ext = m_ext - 1;
        m_cnt = m_cnt - 1;
      end
      if (we && addr == 3'd4) m_pre = wdata;
      if (we && addr == 3'd5) m_ldv = wdata;
      m_eqq = eq; m_pq = pulse; m_cq = cap; m_pa = pa; m_pb = pb;
    end
  end

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_cap;
      3'd2: return m_sc;
      3'd3: return {16'h0, 16'(m_se)};
      3'd4: return m_pre;
      3'd5: return m_ldv;
      3'd6: return {30'h0, m_qerr, m_irq};
      default: return {16'h0, 16'(m_ext)};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R6";
      3'd2: return "R8";
      3'd3: return "R8";
      3'd4: return "R11";
      3'd5: return "R10";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag_of(addr), rdata, model_rd(addr));
      check("R7", {31'h0, cmp}, {31'h0, (m_cnt == m_pre) && !m_eqq});
      check("R7", {31'h0, irq}, {31'h0, m_irq});
      if (cmp) cmp_seen++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic cyc(input logic p, input logic c, input logic s, input logic l);
    @(posedge clk); #1;
    pulse = p; cap = c; snap = s; load = l; we = 0;
  endtask

  task automatic pulse_once();
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    pulse = 0; cap = 0; snap = 0; load = 0;
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    pulse = 0; cap = 0; snap = 0; load = 0; we = 0; addr = a;
    @(negedge clk);
    check(req, rdata, exp);
  endtask

  task automatic quad(input logic a, input logic b);
    @(posedge clk); #1;
    pa = a; pb = b; pulse = 0; cap = 0; snap = 0; load = 0; we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int c0;
    rst_n = 0; mode = 0; pulse = 0; pa = 0; pb = 0; cap = 0; snap = 0;
    load = 0; we = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(3'd0, 32'h0, "R1");
    rd(3'd6, 32'h0, "R1");
    rd(3'd7, 32'h0, "R1");
    check("R1", {31'h0, irq}, 32'h0);

    // R2 up counting
    mode = 2'd0;
    for (int i = 0; i < 5; i++) pulse_once();
    rd(3'd0, 32'd5, "R2");

    // R10 load
    wr(3'd5, 32'hFFFF_FFFE);
    cyc(0, 0, 0, 1);
    rd(3'd0, 32'hFFFF_FFFE, "R10");

    // R9 wrap upward
    for (int i = 0; i < 3; i++) pulse_once();
    rd(3'd0, 32'd1, "R9");
    rd(3'd7, 32'd1, "R9");

    // R3 down counting and wrap downward
    mode = 2'd1;
    pulse_once(); pulse_once();
    rd(3'd0, 32'hFFFF_FFFF, "R3");
    rd(3'd7, 32'd0, "R9");

    // R3 hold mode ignores pulses
    mode = 2'd3;
    pulse_once();
    rd(3'd0, 32'hFFFF_FFFF, "R3");

    // R10 load beats a simultaneous pulse edge; R9 ext untouched
    mode = 2'd0;
    wr(3'd5, 32'h10);
    cyc(1, 0, 0, 1);
    cyc(0, 0, 0, 0);
    rd(3'd0, 32'h10, "R10");
    rd(3'd7, 32'd0, "R9");

    // R4 quadrature forward and reverse
    mode = 2'd2;
    quad(0, 1); quad(1, 1); quad(1, 0); quad(0, 0);
    rd(3'd0, 32'h14, "R4");
    quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
    rd(3'd0, 32'h10, "R4");

    // R5 illegal transitions
    wr(3'd6, 32'h1);
    quad(1, 1); quad(0, 0);
    rd(3'd0, 32'h10, "R5");
    rd(3'd6, 32'h2, "R5");
    wr(3'd6, 32'h2);
    rd(3'd6, 32'h0, "R5");

    // R6 capture together with a step
    mode = 2'd0;
    cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 0);
    rd(3'd1, 32'h10, "R6");
    rd(3'd0, 32'h11, "R6");

    // R7 compare pulse once, sticky interrupt
    wr(3'd4, 32'h13);
    c0 = cmp_seen;
    pulse_once(); pulse_once();
    repeat (5) cyc(0, 0, 0, 0);
    check("R7", cmp_seen - c0, 32'd1);
    rd(3'd6, 32'h1, "R7");
    pulse_once();
    rd(3'd6, 32'h1, "R7");
    wr(3'd6, 32'h1);
    rd(3'd6, 32'h0, "R7");
    check("R7", {31'h0, irq}, 32'h0);

    // R8 snapshot with a step in the same cycle
    cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 0);
    rd(3'd2, 32'h14, "R8");
    rd(3'd3, 32'h0, "R8");
    rd(3'd0, 32'h15, "R8");

    // R11 writes to read-only addresses are ignored
    wr(3'd0, 32'hDEAD_BEEF);
    rd(3'd0, 32'h15, "R11");
    wr(3'd1, 32'h1234_5678);
    rd(3'd1, 32'h10, "R11");
    rd(3'd4, 32'h13, "R11");

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule